// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block is a purely combinational add/subtract unit for a datapath that needs condition codes alongside its sums. It takes two 32-bit operands, a 2-bit operation code, a 2-bit width selector and a carry input. From these it returns the arithmetic result and a 6-bit status vector in the same evaluation. The operand width can be byte (8), half (16) or word (32). The result is cut to that width. Carry, sign and overflow are taken at the top bit of that width, not always at bit 31.

The status vector includes the usual carry, zero, sign and signed-overflow indications. It also carries two less common flags. Parity is an even-ones indicator over the low byte of the result. The nibble auxiliary carry marks a carry or borrow between bit 3 and bit 4. Overflow comes from the operand and result signs, not from the carry chain. This lets overflow and carry be set or clear independently.

There is no state, so the block has no state machine: no states and no transitions. Results settle in the same cycle the inputs change. Flag storage belongs to the consumer.

Top module: `asf_flag_unit`

## Requirements
- R1: `result` holds the low W bits of the arithmetic outcome, where W is 8, 16 or 32 as chosen by `width_sel` (00 = 8, 01 = 16, 10 = 32). All bits of `result` at or above W are 0.
- R2: `op_code` selects the operation: 00 computes a+b, 01 computes a−b, 10 computes a+b+carry_in, 11 computes a−b−carry_in. With codes 00 and 01, `carry_in` has no effect on any output.
- R3: `flags[0]` (carry) is 1 when the addition carries out of bit W−1, or when the subtraction needs a borrow into bit W−1 (unsigned minuend smaller than subtrahend plus borrow). Otherwise it is 0.
- R4: `flags[1]` (parity) is 1 when `result[7:0]` contains an even number of one bits, at every width. Otherwise it is 0.
- R5: `flags[2]` (auxiliary) is 1 when bit 3 carries into bit 4 on addition, or when bit 4 lends a borrow to bit 3 on subtraction.
- R6: `flags[3]` (zero) is 1 exactly when `result` is all zeros.
- R7: `flags[4]` (sign) equals `result[W−1]`.
- R8: `flags[5]` (overflow) is 1 when the signed two's-complement outcome lies outside the range of W bits. For add codes this is when both operands share a sign and the result's sign differs from it. For subtract codes this is when the operands' signs differ and the result's sign differs from the minuend's. Overflow can differ from carry.
- R9: `width_sel` code 11 behaves exactly as code 10 (32 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (minuend for subtraction) |
| op_b | input | 32 | Second operand (subtrahend for subtraction) |
| op_code | input | 2 | Operation select, encoding in R2 |
| width_sel | input | 2 | Operand width select, encoding in R1 and R9 |
| carry_in | input | 1 | Carry for code 10, borrow for code 11 |
| result | output | 32 | Result masked to the selected width |
| flags | output | 6 | Status: [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign, [5] overflow |

## Verification
Carry and signed overflow come from separate logic but can be set by one input. Adding 0x80 to 0x80 at byte width sets both, along with zero and parity. The bench provokes this overlap and the cases where only one of the two is set: 0x7F+1 gives overflow alone, and 0−1 gives carry alone. A reference model computes each flag from widened integer arithmetic, so every flag bit is judged on its own against a model that shares no logic with the carry chain.

// File: rtl/asf_pkg.sv
package asf_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_ADC = 2'b10,
        OP_SBB = 2'b11
    } asf_op_e;

    typedef enum logic [1:0] {
        WD_BYTE = 2'b00,
        WD_HALF = 2'b01,
        WD_WORD = 2'b10,
        WD_WIDE = 2'b11
    } asf_width_e;

    localparam int FLAG_N  = 6;
    localparam int FL_CARRY = 0;
    localparam int FL_PAR   = 1;
    localparam int FL_AUX   = 2;
    localparam int FL_ZERO  = 3;
    localparam int FL_SIGN  = 4;
    localparam int FL_OVF   = 5;

    localparam int NIBBLE_W = 4;
    localparam int PAR_W    = 8;

endpackage

// File: rtl/asf_operand_prep.sv
module asf_operand_prep
    import asf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] b_in,
    input  logic [1:0]        op_code,
    input  logic              carry_in,
    output logic [DATA_W-1:0] b_eff,
    output logic              cin_eff,
    output logic              is_sub
);

    logic use_cin;

    always_comb begin
        unique case (asf_op_e'(op_code))
            OP_ADD: begin is_sub = 1'b0; use_cin = 1'b0; end
            OP_SUB: begin is_sub = 1'b1; use_cin = 1'b0; end
            OP_ADC: begin is_sub = 1'b0; use_cin = 1'b1; end
            OP_SBB: begin is_sub = 1'b1; use_cin = 1'b1; end
            default: begin is_sub = 1'b0; use_cin = 1'b0; end
        endcase
        // Subtraction is a + ~b + 1; a pending borrow removes the +1.
        b_eff   = is_sub ? ~b_in : b_in;
        cin_eff = is_sub ? ~(use_cin & carry_in) : (use_cin & carry_in);
    end

endmodule

// File: rtl/asf_adder.sv
module asf_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W:1]   carry_into
);

    logic [DATA_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};
        sum      = wide_sum[DATA_W-1:0];
    end

    // carry_into[k] is the carry entering bit k, recovered from the
    // half-sum at that bit; the top one is the adder's carry out.
    genvar k;
    generate
        for (k = 1; k < DATA_W; k++) begin : g_carry
            assign carry_into[k] = a_in[k] ^ b_in[k] ^ sum[k];
        end
    endgenerate
    assign carry_into[DATA_W] = wide_sum[DATA_W];

endmodule

// File: rtl/asf_flag_eval.sv
module asf_flag_eval
    import asf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [1:0]        width_sel,
    input  logic              is_sub,
    input  logic              use_cin,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] sum,
    input  logic [DATA_W:1]   carry_into,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_N-1:0] flags
);

    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;
    localparam int IDX_W  = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] mask;
    logic [IDX_W-1:0]  top;
    logic              cout, sa, sb, sr, ovf_add, ovf_sub;

    always_comb begin
        unique case (asf_width_e'(width_sel))
            WD_BYTE: begin mask = DATA_W'((64'd1 << BYTE_W) - 1); top = IDX_W'(BYTE_W); end
            WD_HALF: begin mask = DATA_W'((64'd1 << HALF_W) - 1); top = IDX_W'(HALF_W); end
            WD_WORD: begin mask = '1; top = IDX_W'(DATA_W); end
            WD_WIDE: begin mask = '1; top = IDX_W'(DATA_W); end
            default: begin mask = '1; top = IDX_W'(DATA_W); end
        endcase
    end

    always_comb begin
        result  = sum & mask;
        cout    = carry_into[top];
        sa      = a_in[top - 1'b1];
        sb      = b_in[top - 1'b1];
        sr      = sum[top - 1'b1];
        ovf_add = (sa == sb) && (sr != sa);
        ovf_sub = (sa != sb) && (sr != sa);

        flags[FL_CARRY] = is_sub ? ~cout : cout;
        flags[FL_PAR]   = ~^result[PAR_W-1:0];
        flags[FL_AUX]   = is_sub ? ~carry_into[NIBBLE_W] : carry_into[NIBBLE_W];
        flags[FL_ZERO]  = (result == '0);
        flags[FL_SIGN]  = sr;
        flags[FL_OVF]   = is_sub ? ovf_sub : ovf_add;
    end

    // Guards next to the flag logic.
    logic [DATA_W-1:0] ua, ub;
    logic              ci_v;
    always_comb begin
        ua   = a_in & mask;
        ub   = b_in & mask;
        ci_v = use_cin & carry_in;

        p_upper_zero_r1: assert ((result & ~mask) == '0)
            else $error("R1 upper result bits not cleared");

        // R3: unsigned wrap relation, independent of the carry chain
        if (!is_sub && !ci_v)
            p_add_carry_r3: assert (flags[FL_CARRY] == (result < ua))
                else $error("R3 add carry disagrees with wrap");
        if (is_sub && !ci_v)
            p_sub_borrow_r3: assert (flags[FL_CARRY] == (ua < ub))
                else $error("R3 borrow disagrees with compare");

        // R6: an all-zero result has even parity and a clear sign
        if (flags[FL_ZERO])
            p_zero_implies_r6: assert (flags[FL_PAR] && !flags[FL_SIGN])
                else $error("R6 zero with odd parity or sign set");

        // R8: sign rule must agree with the top two carries
        p_ovf_chain_r8: assert (flags[FL_OVF] == (carry_into[top] ^ carry_into[top - 1'b1]))
            else $error("R8 overflow disagrees with carry chain");
    end

endmodule

// File: rtl/asf_flag_unit.sv
module asf_flag_unit
    import asf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        op_code,
    input  logic [1:0]        width_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic [5:0]        flags
);

    logic [DATA_W-1:0] b_eff, sum;
    logic [DATA_W:1]   carry_into;
    logic              cin_eff, is_sub;

    asf_operand_prep #(.DATA_W(DATA_W)) u_prep (
        .b_in     (op_b),
        .op_code  (op_code),
        .carry_in (carry_in),
        .b_eff    (b_eff),
        .cin_eff  (cin_eff),
        .is_sub   (is_sub)
    );

    asf_adder #(.DATA_W(DATA_W)) u_add (
        .a_in       (op_a),
        .b_in       (b_eff),
        .cin        (cin_eff),
        .sum        (sum),
        .carry_into (carry_into)
    );

    asf_flag_eval #(.DATA_W(DATA_W)) u_flags (
        .a_in       (op_a),
        .b_in       (op_b),
        .width_sel  (width_sel),
        .is_sub     (is_sub),
        .use_cin    (op_code[1]),
        .carry_in   (carry_in),
        .sum        (sum),
        .carry_into (carry_into),
        .result     (result),
        .flags      (flags)
    );

endmodule

// File: tb/sim_asf_flag_unit.sv
`timescale 1ns/1ps
module sim_asf_flag_unit;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] op_a, op_b, result;
    logic [1:0]  op_code, width_sel;
    logic        carry_in;
    logic [5:0]  flags;

    asf_flag_unit u0 (
        .op_a(op_a), .op_b(op_b), .op_code(op_code), .width_sel(width_sel),
        .carry_in(carry_in), .result(result), .flags(flags)
    );

    typedef struct {
        logic [31:0] exp_res;
        logic [5:0]  exp_fl;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    string flag_req [6] = '{"R3 carry", "R4 parity", "R5 aux", "R6 zero", "R7 sign", "R8 overflow"};

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] op, input logic [1:0] ws,
                                  input logic c, output logic [31:0] r,
                                  output logic [5:0] f);
        int w;
        longint m, ua, ub, ci, full, nib, sa, sb, sres, half;
        bit sub;
        w    = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
        m    = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        ua   = longint'(a) & m;
        ub   = longint'(b) & m;
        sub  = op[0];
        ci   = (op[1] && c) ? 1 : 0;
        full = sub ? (ua - ub - ci) : (ua + ub + ci);
        r    = 32'(full & m);
        f[0] = sub ? (full < 0) : (((full >> w) & 1) == 1);
        nib  = sub ? ((ua & 15) - (ub & 15) - ci) : ((ua & 15) + (ub & 15) + ci);
        f[2] = sub ? (nib < 0) : (nib > 15);
        sa   = (ua >= half) ? ua - (half << 1) : ua;
        sb   = (ub >= half) ? ub - (half << 1) : ub;
        sres = sub ? (sa - sb - ci) : (sa + sb + ci);
        f[5] = (sres > half - 1) || (sres < -half);
        f[3] = (r == 32'd0);
        f[4] = r[w-1];
        f[1] = ~^r[7:0];
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] op, input logic [1:0] ws,
                         input logic c, input string tag);
        item_t it;
        @(posedge clk);
        op_a = a; op_b = b; op_code = op; width_sel = ws; carry_in = c;
        model(a, b, op, ws, c, it.exp_res, it.exp_fl);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            bit bad;
            it  = sb_q.pop_front();
            bad = 0;
            vectors++;
            if (result !== it.exp_res) begin
                bad = 1;
                $display("FAIL %s R1 result: actual %08h expected %08h", it.tag, result, it.exp_res);
            end
            for (int i = 0; i < 6; i++) begin
                if (flags[i] !== it.exp_fl[i]) begin
                    bad = 1;
                    $display("FAIL %s %s flag: actual %0b expected %0b", it.tag, flag_req[i], flags[i], it.exp_fl[i]);
                end
            end
            if (bad) miscompares++;
        end
    end

    initial begin
        op_a = '0; op_b = '0; op_code = '0; width_sel = '0; carry_in = 1'b0;
        // idle inputs: zero result, zero and parity set
        drive(32'h0, 32'h0, 2'b00, 2'b00, 1'b0, "R6 R4 idle");
        // carry and overflow together at byte width
        drive(32'h80, 32'h80, 2'b00, 2'b00, 1'b0, "R3 R8 both");
        drive(32'h0F, 32'h01, 2'b00, 2'b00, 1'b0, "R5 nibble carry");
        drive(32'h7F, 32'h01, 2'b00, 2'b00, 1'b0, "R8 R7 ovf only");
        drive(32'hFF, 32'h01, 2'b00, 2'b01, 1'b0, "R3 no carry at half");
        drive(32'hFFFF, 32'h1, 2'b00, 2'b01, 1'b0, "R3 half carry");
        drive(32'h0, 32'h1, 2'b01, 2'b10, 1'b0, "R3 R5 borrow only");
        drive(32'h80000000, 32'h1, 2'b01, 2'b10, 1'b0, "R8 sub ovf");
        drive(32'h5, 32'h3, 2'b10, 2'b00, 1'b1, "R2 adc");
        drive(32'h5, 32'h3, 2'b00, 2'b00, 1'b1, "R2 add ignores cin");
        drive(32'h5, 32'h3, 2'b11, 2'b00, 1'b1, "R2 sbb");
        drive(32'h5, 32'h3, 2'b01, 2'b00, 1'b1, "R2 sub ignores cin");
        drive(32'hFFFFFFFF, 32'h1, 2'b00, 2'b11, 1'b0, "R9 code 11 word");
        drive(32'h12345678, 32'h11111111, 2'b00, 2'b00, 1'b0, "R1 upper masked");
        drive(32'h00000300, 32'h00000100, 2'b00, 2'b01, 1'b0, "R4 parity low byte");
        drive(32'h10, 32'h01, 2'b01, 2'b00, 1'b0, "R5 nibble borrow");
        drive(32'h0, 32'h0, 2'b11, 2'b00, 1'b1, "R3 sbb borrow");
        drive(32'hFF, 32'hFF, 2'b10, 2'b00, 1'b1, "R3 adc full");
        for (int n = 0; n < 400; n++) begin
            drive($urandom, $urandom, 2'($urandom), 2'($urandom), 1'($urandom),
                  "R1 R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end
        @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule